// File: doc/BRIEF.md
# ECC Line-Delete Tracking Controller

This block sits beside a small set-associative data array with several ways per row. Every stored word gets seven check bits from a single-error-correct, double-error-detect code. On readout the word is checked: a single flipped bit is repaired on the fly, and two flipped bits are reported as uncorrectable. The array is held inside the block as plain registers. A write-side fault mask models defective cells by flipping chosen codeword bits as they are stored.

Each row/way entry owns a saturating counter of uncorrectable reads. When the counter of the entry just read reaches a software-set threshold, the block raises a service request that names that row and way. Software then retires the entry with a delete command, which also acknowledges the request, or simply acknowledges it with a clear command. A retired entry is never written again. Writes aimed at it move to the lowest-numbered live way of the same row. Reads of it return zero with a flag. The other ways of the row keep working, so the only cost is reduced capacity.

Top module: `ecc_line_retire`

## Requirements
- R1: A read issued with `rd_en_i` in one cycle shows `rd_valid_o`, with the stored word on `rd_data_o`, in the next cycle. `rd_corr_o`, `rd_uncorr_o` and `rd_deleted_o` are low whenever `rd_valid_o` is low.
- R2: The stored codeword is data bits [31:0], check bits [37:32] and an overall parity bit [38]; `wr_fault_i` is XORed into it when it is stored. With exactly one bit of the mask set, the read returns the original data and pulses `rd_corr_o` for one cycle.
- R3: With exactly two mask bits set, the read pulses `rd_uncorr_o` for one cycle and returns zero data. At most one of the three read flags is high in any cycle.
- R4: Each uncorrectable read of a live entry raises that entry's counter by one. The counter saturates at 7 instead of wrapping.
- R5: When no request is pending and an uncorrectable read leaves its entry's counter at or above the threshold, `svc_req_o` rises in the next cycle, with `svc_row_o`/`svc_way_o` naming that entry. An entry that crosses the threshold while a request is pending raises no request of its own.
- R6: `svc_req_o` and the entry it names stay unchanged until software acknowledges. An acknowledge is either a delete command or a clear command (`cfg_op_i` = 3), and `svc_req_o` falls in the following cycle.
- R7: The threshold is 2 after reset. The command `cfg_op_i` = 1 loads it from `cfg_data_i[2:0]`.
- R8: The command `cfg_op_i` = 2 retires the entry with way `cfg_data_i[1:0]` and row `cfg_data_i[4:2]`. A read of a retired entry returns zero data with `rd_deleted_o` and changes no counter.
- R9: A write aimed at a retired entry is stored into the lowest-numbered live way of the same row. The other entries of that row, and of every other row, keep their contents.
- R10: When every way of the addressed row is retired, the write is discarded and `wr_drop_o` pulses in the next cycle.
- R11: Reset clears all counters, all retire marks and any pending request, and brings every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_row_i | input | 3 | Write row |
| wr_way_i | input | 2 | Write way |
| wr_data_i | input | 32 | Write data |
| wr_fault_i | input | 39 | Codeword bits flipped when stored (defect model) |
| rd_en_i | input | 1 | Read strobe |
| rd_row_i | input | 3 | Read row |
| rd_way_i | input | 2 | Read way |
| cfg_op_i | input | 2 | Command: 0 none, 1 threshold, 2 delete, 3 clear |
| cfg_data_i | input | 5 | Command operand |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 32 | Corrected read data |
| rd_corr_o | output | 1 | Single-bit error repaired |
| rd_uncorr_o | output | 1 | Uncorrectable error |
| rd_deleted_o | output | 1 | Read hit a retired entry |
| wr_drop_o | output | 1 | Write discarded, row fully retired |
| svc_req_o | output | 1 | Service request pending |
| svc_row_o | output | 3 | Row of the requesting entry |
| svc_way_o | output | 2 | Way of the requesting entry |

## Verification
Every result appears exactly one clock edge after the edge that takes in its stimulus. This covers the read word and flags, the drop pulse, a newly raised or dropped service request, and a new threshold or retire mark as seen by later traffic. A read and a write to the same entry in one cycle read the old contents. The bench drives inputs at the falling edge and steps a behavioural model at the rising edge using the inputs and state from before that edge. It compares every output at the following falling edge, so each comparison lands in the cycle its result is due. Error counts are driven by fault masks of known population rather than by code values.

// File: rtl/lr_pkg.sv
package lr_pkg;

  typedef enum logic [1:0] {
    CFG_NONE   = 2'd0,
    CFG_THRESH = 2'd1,
    CFG_DELETE = 2'd2,
    CFG_CLEAR  = 2'd3
  } cfg_op_e;

  // check bits needed for a single-error-correcting code over dw bits
  function automatic int parity_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Hamming position (1-based, skipping powers of two) of data bit k
  function automatic int data_pos(input int k);
    int pos;
    int n;
    pos = 2;
    n   = -1;
    while (n < k) begin
      pos++;
      if ((pos & (pos - 1)) != 0) n++;
    end
    return pos;
  endfunction

endpackage

// File: rtl/lr_secded_enc.sv
module lr_secded_enc #(
  parameter int DW = 32,
  localparam int PW = lr_pkg::parity_bits(DW),
  localparam int CW = DW + PW + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);

  logic [PW-1:0] chk;

  always_comb begin
    chk = '0;
    for (int k = 0; k < DW; k++) begin
      if (data_i[k]) chk ^= PW'(lr_pkg::data_pos(k));
    end
  end

  // layout: overall parity, check bits, data
  assign code_o = {^{chk, data_i}, chk, data_i};

endmodule

// File: rtl/lr_secded_dec.sv
module lr_secded_dec #(
  parameter int DW = 32,
  localparam int PW = lr_pkg::parity_bits(DW),
  localparam int CW = DW + PW + 1,
  localparam int HN = DW + PW
) (
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          corr_o,
  output logic          uncorr_o
);

  logic [DW-1:0] raw;
  logic [PW-1:0] syn;
  logic          par;
  logic          fixable;

  assign raw = code_i[DW-1:0];
  assign par = ^code_i;

  always_comb begin
    syn = code_i[DW +: PW];
    for (int k = 0; k < DW; k++) begin
      if (raw[k]) syn ^= PW'(lr_pkg::data_pos(k));
    end
  end

  assign fixable  = (int'(syn) <= HN);
  assign corr_o   = par && fixable;
  assign uncorr_o = (!par && (syn != '0)) || (par && !fixable);

  always_comb begin
    for (int k = 0; k < DW; k++) begin
      data_o[k] = raw[k] ^ (corr_o && (syn == PW'(lr_pkg::data_pos(k))));
    end
  end

endmodule

// File: rtl/lr_way_map.sv
module lr_way_map #(
  parameter int ROWS = 8,
  parameter int WAYS = 4,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             del_set_i,
  input  logic [ROW_W-1:0] del_row_i,
  input  logic [WAY_W-1:0] del_way_i,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [WAY_W-1:0] wr_way_i,
  output logic             wr_go_o,
  output logic             wr_drop_o,
  output logic [WAY_W-1:0] wr_tgt_o,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [WAY_W-1:0] rd_way_i,
  output logic             rd_del_o
);

  logic [WAYS-1:0] del_q [ROWS];
  logic [WAYS-1:0] del_d [ROWS];
  logic [WAYS-1:0] row_del;
  logic            wr_ok;

  always_comb begin
    del_d = del_q;
    if (del_set_i) del_d[del_row_i][del_way_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) del_q[r] <= '0;
    end else if (del_set_i) begin
      del_q <= del_d;
    end
  end

  // redirect: lowest-numbered live way of the row
  always_comb begin
    row_del  = del_q[wr_row_i];
    wr_tgt_o = wr_way_i;
    wr_ok    = 1'b1;
    if (row_del[wr_way_i]) begin
      wr_ok = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!row_del[w]) begin
          wr_tgt_o = WAY_W'(w);
          wr_ok    = 1'b1;
        end
      end
    end
  end

  assign wr_go_o   = wr_en_i && wr_ok;
  assign wr_drop_o = wr_en_i && !wr_ok;
  assign rd_del_o  = del_q[rd_row_i][rd_way_i];

  AST_NO_DEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_o |-> !row_del[wr_tgt_o]); // R9
  AST_DROP_ALL_DEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> (&row_del)); // R10

  for (genvar r = 0; r < ROWS; r++) begin : g_sticky
    AST_DEL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((del_q[r] & $past(del_q[r])) == $past(del_q[r]))); // R8
  end

endmodule

// File: rtl/lr_err_track.sv
module lr_err_track #(
  parameter int ROWS    = 8,
  parameter int WAYS    = 4,
  parameter int CNT_W   = 3,
  parameter int THR_RST = 2,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int ENT   = ROWS * WAYS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ue_i,
  input  logic [ROW_W-1:0] ue_row_i,
  input  logic [WAY_W-1:0] ue_way_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             ack_i,
  output logic             svc_o,
  output logic [ROW_W-1:0] svc_row_o,
  output logic [WAY_W-1:0] svc_way_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q [ENT];
  logic [CNT_W-1:0] cnt_d [ENT];
  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] cur;
  logic [CNT_W-1:0] nxt;
  logic             pend_q;
  logic             pend_d;
  logic             raise;
  int               idx;

  always_comb begin
    idx   = int'(ue_row_i) * WAYS + int'(ue_way_i);
    cnt_d = cnt_q;
    cur   = cnt_q[idx];
    nxt   = (cur == CMAX) ? cur : cur + 1'b1;
    if (ue_i) cnt_d[idx] = nxt;
    raise  = ue_i && !pend_q && (nxt >= thr_q);
    pend_d = raise || (pend_q && !ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENT; e++) cnt_q[e] <= '0;
      thr_q     <= CNT_W'(THR_RST);
      pend_q    <= 1'b0;
      svc_row_o <= '0;
      svc_way_o <= '0;
    end else begin
      if (ue_i)     cnt_q  <= cnt_d;
      if (thr_we_i) thr_q  <= thr_i;
      pend_q <= pend_d;
      if (raise) begin
        svc_row_o <= ue_row_i;
        svc_way_o <= ue_way_i;
      end
    end
  end

  assign svc_o = pend_q;

  AST_SVC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> pend_q); // R6
  AST_SVC_ID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ack_i) |=> ($stable(svc_row_o) && $stable(svc_way_o))); // R5
  AST_SVC_FROM_UE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(ue_i)); // R5

  for (genvar e = 0; e < ENT; e++) begin : g_sat
    AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q[e] == CMAX) |=> (cnt_q[e] == CMAX)); // R4
  end

endmodule

// File: rtl/ecc_line_retire.sv
module ecc_line_retire #(
  parameter int ROWS    = 8,
  parameter int WAYS    = 4,
  parameter int DW      = 32,
  parameter int CNT_W   = 3,
  parameter int THR_RST = 2,
  localparam int ROW_W = $clog2(ROWS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PW    = lr_pkg::parity_bits(DW),
  localparam int CW    = DW + PW + 1,
  localparam int ENT   = ROWS * WAYS,
  localparam int CFG_W = (ROW_W + WAY_W > CNT_W) ? ROW_W + WAY_W : CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [CW-1:0]    wr_fault_i,
  input  logic             rd_en_i,
  input  logic [ROW_W-1:0] rd_row_i,
  input  logic [WAY_W-1:0] rd_way_i,
  input  logic [1:0]       cfg_op_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_corr_o,
  output logic             rd_uncorr_o,
  output logic             rd_deleted_o,
  output logic             wr_drop_o,
  output logic             svc_req_o,
  output logic [ROW_W-1:0] svc_row_o,
  output logic [WAY_W-1:0] svc_way_o
);

  import lr_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // command decode
  cfg_op_e cmd;
  logic    thr_we;
  logic    del_set;
  logic    ack;

  assign cmd     = cfg_op_e'(cfg_op_i);
  assign thr_we  = (cmd == CFG_THRESH);
  assign del_set = (cmd == CFG_DELETE);
  assign ack     = del_set || (cmd == CFG_CLEAR);

  // retire map and write steering
  logic             wr_go;
  logic             wr_drop_d;
  logic [WAY_W-1:0] wr_tgt;
  logic             rd_del;

  lr_way_map #(.ROWS(ROWS), .WAYS(WAYS)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .del_set_i (del_set),
    .del_row_i (cfg_data_i[WAY_W +: ROW_W]),
    .del_way_i (cfg_data_i[WAY_W-1:0]),
    .wr_en_i   (wr_en_i),
    .wr_row_i  (wr_row_i),
    .wr_way_i  (wr_way_i),
    .wr_go_o   (wr_go),
    .wr_drop_o (wr_drop_d),
    .wr_tgt_o  (wr_tgt),
    .rd_row_i  (rd_row_i),
    .rd_way_i  (rd_way_i),
    .rd_del_o  (rd_del)
  );

  // storage
  logic [CW-1:0] enc_code;
  logic [CW-1:0] mem_q [ENT];
  int            widx;
  int            ridx;

  lr_secded_enc #(.DW(DW)) u_enc (.data_i(wr_data_i), .code_o(enc_code));

  assign widx = int'(wr_row_i) * WAYS + int'(wr_tgt);
  assign ridx = int'(rd_row_i) * WAYS + int'(rd_way_i);

  always_ff @(posedge clk_i) begin
    if (wr_go) mem_q[widx] <= enc_code ^ wr_fault_i;
  end

  // read check
  logic [DW-1:0] dec_data;
  logic          dec_corr;
  logic          dec_uncorr;
  logic          rd_live;
  logic          ue_hit;

  lr_secded_dec #(.DW(DW)) u_dec (
    .code_i   (mem_q[ridx]),
    .data_o   (dec_data),
    .corr_o   (dec_corr),
    .uncorr_o (dec_uncorr)
  );

  assign rd_live = rd_en_i && !rd_del;
  assign ue_hit  = rd_live && dec_uncorr;

  lr_err_track #(.ROWS(ROWS), .WAYS(WAYS), .CNT_W(CNT_W), .THR_RST(THR_RST)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ue_i      (ue_hit),
    .ue_row_i  (rd_row_i),
    .ue_way_i  (rd_way_i),
    .thr_we_i  (thr_we),
    .thr_i     (cfg_data_i[CNT_W-1:0]),
    .ack_i     (ack),
    .svc_o     (svc_req_o),
    .svc_row_o (svc_row_o),
    .svc_way_o (svc_way_o)
  );

  // registered read result
  logic [DW-1:0] rd_data_d;

  assign rd_data_d = (rd_live && !dec_uncorr) ? dec_data : '0;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      rd_corr_o    <= 1'b0;
      rd_uncorr_o  <= 1'b0;
      rd_deleted_o <= 1'b0;
      wr_drop_o    <= 1'b0;
    end else begin
      rd_valid_o   <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_data_d;
      rd_corr_o    <= rd_live && dec_corr;
      rd_uncorr_o  <= ue_hit;
      rd_deleted_o <= rd_en_i && rd_del;
      wr_drop_o    <= wr_drop_d;
    end
  end

  AST_RD_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_valid_o |-> $onehot0({rd_corr_o, rd_uncorr_o, rd_deleted_o})); // R3
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rd_valid_o |-> !(rd_corr_o || rd_uncorr_o || rd_deleted_o)); // R1
  AST_RETIRED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_deleted_o |-> (rd_data_o == '0)); // R8
  AST_DROP_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_drop_o |-> $past(wr_en_i)); // R10

endmodule

// File: tb/test_ecc_line_retire.sv
`timescale 1ns/1ps
module test_ecc_line_retire;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_row;
  logic [1:0]  wr_way;
  logic [31:0] wr_data;
  logic [38:0] wr_fault;
  logic        rd_en;
  logic [2:0]  rd_row;
  logic [1:0]  rd_way;
  logic [1:0]  cfg_op;
  logic [4:0]  cfg_data;
  logic        rd_valid, rd_corr, rd_uncorr, rd_deleted, wr_drop, svc_req;
  logic [31:0] rd_data;
  logic [2:0]  svc_row;
  logic [1:0]  svc_way;

  always #4 clk = ~clk;

  ecc_line_retire i_ecc_line_retire (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_way_i(wr_way),
    .wr_data_i(wr_data), .wr_fault_i(wr_fault),
    .rd_en_i(rd_en), .rd_row_i(rd_row), .rd_way_i(rd_way),
    .cfg_op_i(cfg_op), .cfg_data_i(cfg_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_corr_o(rd_corr),
    .rd_uncorr_o(rd_uncorr), .rd_deleted_o(rd_deleted), .wr_drop_o(wr_drop),
    .svc_req_o(svc_req), .svc_row_o(svc_row), .svc_way_o(svc_way)
  );

  int    n_chk = 0;
  int    n_err = 0;
  string tag   = "R11";

  // behavioural model
  logic [31:0] m_data [32];
  int          m_flip [32];
  int          m_cnt  [32];
  bit          m_del  [32];
  int          m_thr;
  bit          m_pend;
  int          m_srow, m_sway;
  bit          e_rv, e_c, e_u, e_d, e_drop;
  logic [31:0] e_rd;

  function automatic void model_reset();
    for (int e = 0; e < 32; e++) begin m_cnt[e] = 0; m_del[e] = 0; end
    m_thr = 2; m_pend = 0; m_srow = 0; m_sway = 0;
  endfunction

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int  idx;
    int  tw;
    bit  ue;
    bit  ack;
    @(posedge clk);
    e_rv = rd_en; e_c = 0; e_u = 0; e_d = 0; ue = 0; idx = 0;
    if (rd_en) begin
      idx = int'(rd_row) * 4 + int'(rd_way);
      if (m_del[idx])            begin e_d = 1; e_rd = '0; end
      else if (m_flip[idx] == 2) begin e_u = 1; e_rd = '0; ue = 1; end
      else begin e_rd = m_data[idx]; e_c = (m_flip[idx] == 1); end
    end
    ack = (cfg_op == 2'd2) || (cfg_op == 2'd3);
    if (ue) begin
      if (m_cnt[idx] < 7) m_cnt[idx]++;
      if (!m_pend && m_cnt[idx] >= m_thr) begin
        m_pend = 1; m_srow = int'(rd_row); m_sway = int'(rd_way); ack = 0;
      end
    end
    if (ack) m_pend = 0;
    e_drop = 0;
    if (wr_en) begin
      tw = -1;
      if (!m_del[int'(wr_row) * 4 + int'(wr_way)]) tw = int'(wr_way);
      else for (int w = 3; w >= 0; w--) if (!m_del[int'(wr_row) * 4 + w]) tw = w;
      if (tw < 0) e_drop = 1;
      else begin
        m_data[int'(wr_row) * 4 + tw] = wr_data;
        m_flip[int'(wr_row) * 4 + tw] = $countones(wr_fault);
      end
    end
    if (cfg_op == 2'd1) m_thr = int'(cfg_data[2:0]);
    if (cfg_op == 2'd2) m_del[int'(cfg_data[4:2]) * 4 + int'(cfg_data[1:0])] = 1;
    @(negedge clk);
    chk(rd_valid == e_rv, "rd_valid", rd_valid, e_rv);
    chk(wr_drop == e_drop, "wr_drop", wr_drop, e_drop);
    chk(svc_req == m_pend, "svc_req", svc_req, m_pend);
    if (e_rv) begin
      chk(rd_data == e_rd, "rd_data", rd_data, e_rd);
      chk(rd_corr == e_c, "rd_corr", rd_corr, e_c);
      chk(rd_uncorr == e_u, "rd_uncorr", rd_uncorr, e_u);
      chk(rd_deleted == e_d, "rd_deleted", rd_deleted, e_d);
    end else begin
      chk(!(rd_corr || rd_uncorr || rd_deleted), "flags idle", {rd_corr, rd_uncorr, rd_deleted}, 0);
    end
    if (m_pend) begin
      chk(int'(svc_row) == m_srow, "svc_row", svc_row, m_srow);
      chk(int'(svc_way) == m_sway, "svc_way", svc_way, m_sway);
    end
  endtask

  task automatic idle_in();
    wr_en = 0; wr_row = 0; wr_way = 0; wr_data = 0; wr_fault = 0;
    rd_en = 0; rd_row = 0; rd_way = 0; cfg_op = 0; cfg_data = 0;
  endtask

  task automatic do_wr(input int r, input int w, input logic [31:0] d, input logic [38:0] f);
    wr_en = 1; wr_row = 3'(r); wr_way = 2'(w); wr_data = d; wr_fault = f;
    step(); idle_in();
  endtask

  task automatic do_rd(input int r, input int w);
    rd_en = 1; rd_row = 3'(r); rd_way = 2'(w);
    step(); idle_in();
  endtask

  task automatic do_cfg(input int op, input int d);
    cfg_op = 2'(op); cfg_data = 5'(d);
    step(); idle_in();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_in(); model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tag = "R11";
    chk(!rd_valid && !wr_drop && !svc_req && !rd_corr && !rd_uncorr && !rd_deleted,
        "outputs after reset", {rd_valid, wr_drop, svc_req, rd_corr, rd_uncorr, rd_deleted}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int e = 0; e < 32; e++) begin m_data[e] = '0; m_flip[e] = 0; end
    idle_in();
    do_reset();

    tag = "R1";
    do_wr(0, 0, 32'hA5A5_5A5A, '0);
    do_wr(3, 2, 32'h1234_5678, '0);
    do_rd(0, 0);
    do_rd(3, 2);
    do_wr(7, 3, 32'hFFFF_FFFF, '0);
    do_rd(7, 3);

    tag = "R2";
    do_wr(1, 1, 32'hDEAD_BEEF, 39'h1 << 5);
    do_rd(1, 1);
    do_wr(1, 2, 32'h0BAD_F00D, 39'h1 << 38);
    do_rd(1, 2);
    do_wr(1, 3, 32'h8000_0001, 39'h1 << 33);
    do_rd(1, 3);

    tag = "R3";
    do_wr(2, 0, 32'hCAFE_0001, (39'h1 << 3) | (39'h1 << 20));
    do_rd(2, 0);
    tag = "R5";
    do_rd(2, 0);
    tag = "R6";
    do_rd(2, 0);
    do_wr(2, 1, 32'h5555_AAAA, (39'h1 << 0) | (39'h1 << 37));
    do_rd(2, 1);
    do_rd(2, 1);
    do_cfg(3, 0);
    tag = "R5";
    do_rd(2, 1);
    tag = "R6";
    do_cfg(2, (2 << 2) | 1);

    tag = "R8";
    do_rd(2, 1);
    do_rd(2, 1);
    do_rd(2, 1);

    tag = "R9";
    do_wr(2, 1, 32'h1357_9BDF, '0);
    do_rd(2, 0);
    do_rd(2, 1);
    do_cfg(2, (2 << 2) | 0);
    do_wr(2, 0, 32'h2468_ACE0, '0);
    do_rd(2, 2);
    do_rd(3, 2);

    tag = "R10";
    do_cfg(2, (2 << 2) | 2);
    do_cfg(2, (2 << 2) | 3);
    do_wr(2, 3, 32'h7777_7777, '0);
    do_rd(2, 3);
    do_rd(2, 0);
    do_rd(0, 0);

    tag = "R7";
    do_cfg(1, 4);
    do_wr(5, 3, 32'h0F0F_0F0F, (39'h1 << 10) | (39'h1 << 11));
    for (int i = 0; i < 4; i++) do_rd(5, 3);
    do_cfg(3, 0);

    tag = "R4";
    do_cfg(1, 7);
    do_wr(6, 0, 32'h600D_600D, (39'h1 << 31) | (39'h1 << 32));
    for (int i = 0; i < 8; i++) do_rd(6, 0);
    do_cfg(3, 0);
    do_rd(6, 0);
    do_cfg(3, 0);

    do_reset();
    tag = "R11";
    do_wr(2, 1, 32'h3C3C_C3C3, '0);
    do_rd(2, 1);
    do_rd(6, 0);
    do_rd(6, 0);
    do_cfg(3, 0);
    step();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule